// File: doc/BRIEF.md
# Adaptive Exponential Backoff Timer

This block is a per-requester delay generator for a requester that keeps retrying a test-and-set lock. Each time an attempt fails, the block draws a random wait from a uniform range centred on a mean that it keeps internally. It counts that wait down, then pulses a ready signal to say the requester may try again.

The mean is always a power of two. It starts at one cycle and doubles on every failure until it reaches a ceiling. When a fresh synchronization period begins, the mean drops to half of the value it had reached, and never goes below one. A success stops any wait in progress and leaves the mean as it is, so that the next period starts from half of it. The random bits come from a free-running 16-bit LFSR inside the block.

Top module: `backoff_timer`

## Requirements
- R1: While rst_ni is low, and after it rises, retry_ready_o is 0, the mean is 1 cycle, and the LFSR holds 16'hACE1.
- R2: On a failure, the wait W is the LFSR state present at that clock edge ANDed with (2*mean-1). The LFSR shifts left by one bit on every clock edge, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10.
- R3: retry_ready_o is high for exactly one cycle. That cycle is the (W+1)-th cycle after the edge that samples the failure, so a wait of zero gives ready in the cycle right after the failure.
- R4: Every accepted failure doubles the mean for later draws, up to a ceiling of 2**EXP_MAX cycles (16384 by default). At the ceiling the mean stays where it is.
- R5: A new_period_i pulse sets the mean to half of its current value, but never below 1.
- R6: A success_i pulse cancels any countdown in progress, so no ready follows. The mean is kept unchanged.
- R7: If fail_i and success_i are high in the same cycle, the failure is ignored: no countdown starts and the mean does not double.
- R8: If fail_i and new_period_i are high in the same cycle, the mean is halved first. The wait is then drawn with the halved mean, and the halved mean is doubled.
- R9: A failure that arrives during a countdown restarts it with a fresh draw. Only the new wait produces a ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fail_i | input | 1 | Pulse: the lock attempt failed |
| success_i | input | 1 | Pulse: the lock was acquired |
| new_period_i | input | 1 | Pulse: a fresh synchronization period starts |
| retry_ready_o | output | 1 | One-cycle pulse: the wait has elapsed |

## Verification
The bench builds the block with EXP_MAX=4, so the mean tops out at 16 cycles and every wait fits in five bits. With that setting, a dozen failures push the mean from 1 to the ceiling and hold it there. Halving sequences run down to the floor in a few pulses, and every drawn wait is short enough to be timed exactly against an LFSR model kept in the bench. Combinations of the three pulses in the same cycle, and failures that arrive during a countdown, are swept over a long mixed pattern.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  typedef logic [LFSR_W-1:0] lfsr_t;

  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr
  import backoff_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output lfsr_t state_o
);
  lfsr_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LFSR_SEED;
    else         state_q <= lfsr_step(state_q);
  end

  assign state_o = state_q;

  a_r2_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/bo_mean.sv
module bo_mean #(
  parameter int unsigned EXP_MAX = 14,
  localparam int unsigned EXP_W = $clog2(EXP_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fail_i,
  input  logic             new_period_i,
  output logic [EXP_W-1:0] draw_exp_o
);
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

  logic [EXP_W-1:0] exp_q, exp_eff, exp_d;

  // halve first, then the failure draws from and doubles the halved mean
  always_comb begin
    exp_eff = exp_q;
    if (new_period_i && exp_q != '0) exp_eff = exp_q - EXP_W'(1);
    exp_d = exp_eff;
    if (fail_i && exp_eff != EXP_TOP) exp_d = exp_eff + EXP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= '0;
    else         exp_q <= exp_d;
  end

  assign draw_exp_o = exp_eff;

  a_r4_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i && !new_period_i && exp_q < EXP_TOP |=> exp_q == $past(exp_q) + EXP_W'(1));
  a_r4_hold_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i && !new_period_i && exp_q == EXP_TOP |=> exp_q == EXP_TOP);
  a_r5_halve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_period_i && !fail_i && exp_q != '0 |=> exp_q == $past(exp_q) - EXP_W'(1));
  a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_period_i && !fail_i && exp_q == '0 |=> exp_q == '0);
  a_r8_net_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_period_i && fail_i && exp_q != '0 |=> exp_q == $past(exp_q));
endmodule

// File: rtl/bo_countdown.sv
module bo_countdown #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cancel_i,
  output logic             ready_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= load_val_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  assign ready_o = active_q && (cnt_q == '0);

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !load_i |=> !ready_o);
  a_r6_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !ready_o);
  a_r9_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !cancel_i |=> active_q && cnt_q == $past(load_val_i));
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
  import backoff_pkg::*;
#(
  parameter int unsigned EXP_MAX = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic success_i,
  input  logic new_period_i,
  output logic retry_ready_o
);
  localparam int unsigned EXP_W = $clog2(EXP_MAX + 1);
  localparam int unsigned CNT_W = EXP_MAX + 1;

  logic             fail_ok;
  logic [EXP_W-1:0] draw_exp;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] wait_val;
  lfsr_t            rnd;

  assign fail_ok = fail_i && !success_i;

  bo_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd)
  );

  bo_mean #(.EXP_MAX(EXP_MAX)) u_mean (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fail_i       (fail_ok),
    .new_period_i (new_period_i),
    .draw_exp_o   (draw_exp)
  );

  // mask = 2*mean - 1
  assign span     = ((CNT_W+1)'(1) << (draw_exp + EXP_W'(1))) - (CNT_W+1)'(1);
  assign wait_val = rnd[CNT_W-1:0] & span[CNT_W-1:0];

  bo_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fail_ok),
    .load_val_i (wait_val),
    .cancel_i   (success_i),
    .ready_o    (retry_ready_o)
  );

  initial a_cfg_width: assert (CNT_W <= LFSR_W);

  a_r7_fail_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i && success_i |=> !retry_ready_o);
endmodule

// File: tb/tb_backoff_timer.sv
module tb_backoff_timer;
  localparam int EXP_MAX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail = 1'b0, succ = 1'b0, newp = 1'b0;
  logic ready;
  logic [15:0] m_lfsr;
  int m_exp = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  backoff_timer #(.EXP_MAX(EXP_MAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fail_i(fail), .success_i(succ),
    .new_period_i(newp), .retry_ready_o(ready)
  );

  // reference sequence from R2
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 16'hACE1;
    else m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // drive one cycle of pulses; returns expected wait or -1
  task automatic pulse(input bit f, input bit s, input bit n, output int w);
    int e;
    @(negedge clk);
    fail = f; succ = s; newp = n;
    e = (n && m_exp > 0) ? m_exp - 1 : m_exp;
    w = -1;
    if (f && !s) begin
      w = int'(m_lfsr & 16'((1 << (e + 1)) - 1));
      m_exp = (e < EXP_MAX) ? e + 1 : e;
    end else m_exp = e;
    @(negedge clk);
    fail = 1'b0; succ = 1'b0; newp = 1'b0;
  endtask

  // called at the first negedge after the sampling edge
  task automatic observe(input int w, input string req);
    int bad_j = -1, bad_v = 0;
    for (int j = 0; j <= w + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (ready !== (j == w) && bad_j < 0) begin bad_j = j; bad_v = ready; end
    end
    chk(bad_j < 0, req, bad_j, w);
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge clk);
      if (ready !== 1'b0) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w, w2;
    repeat (3) @(negedge clk);
    chk(ready === 1'b0, "R1 ready in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b0, "R1 ready after reset", ready, 0);

    // R1 R2: first draw with mean 1
    pulse(1, 0, 0, w); observe(w, "R1 R2 first draw");
    // R3 R4: climb to the ceiling and stay there
    for (int i = 0; i < 10; i++) begin
      pulse(1, 0, 0, w); observe(w, i < 4 ? "R3 R4 doubling" : "R4 capped");
    end
    // R5: halving, then down to the floor
    pulse(0, 0, 1, w); pulse(1, 0, 0, w); observe(w, "R5 halved");
    for (int i = 0; i < 7; i++) pulse(0, 0, 1, w);
    pulse(1, 0, 0, w); observe(w, "R5 floor");

    // R6: cancel mid-countdown, mean kept
    for (int i = 0; i < 5; i++) begin pulse(1, 0, 0, w); observe(w, "R4 climb"); end
    w = 0;
    for (int t = 0; t < 20 && w == 0; t++) begin
      pulse(1, 0, 0, w);
      if (w == 0) observe(0, "R3 zero wait");
    end
    succ = 1'b1; @(negedge clk); succ = 1'b0;
    quiet(40, "R6 cancelled");
    pulse(0, 0, 1, w); pulse(1, 0, 0, w); observe(w, "R6 mean kept");

    // R7: simultaneous fail and success
    pulse(1, 1, 0, w); quiet(40, "R7 fail ignored");
    pulse(1, 0, 0, w); observe(w, "R7 mean unchanged");

    // R8: simultaneous fail and new period
    for (int i = 0; i < 3; i++) begin
      pulse(1, 0, 1, w); observe(w, "R8 halve then draw");
    end

    // R9: restart during countdown
    for (int i = 0; i < 6; i++) begin
      pulse(1, 0, 0, w);
      pulse(1, 0, 0, w2); observe(w2, "R9 restart");
    end

    // mixed sweep
    for (int i = 0; i < 60; i++) begin
      bit f, s, n;
      f = (i % 3) != 2; s = (i % 7) == 3; n = (i % 4) == 0;
      pulse(f, s, n, w);
      if (w >= 0) observe(w, "R2 R3 R8 sweep");
      else quiet(4, "R6 R7 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule